// File: doc/BRIEF.md
# Bit-Banged PHY Management Responder

This block stands in for an Ethernet PHY on the management bus when software drives that bus by writing clock and data bits into a register. The block watches three input bits: the management clock, the data bit that software sends, and a read-mode flag. It samples them on every cycle of the system clock. A management-clock bit that goes from 0 to 1 counts as one serial bit. On that bit the block shifts the data bit into a 32-bit word and advances a bit counter. When the counter reaches 16 the block decodes a read header. When it reaches 32 it decodes a full write frame.

The block holds a file of 32 PHY registers, each 16 bits wide. It answers at a single PHY address and ignores every other address. Each register has a writable mask. A write changes only the bits that are set in that register's mask, and the other bits keep their current value. Read data goes back to software one bit per clock edge on a registered data-in bit. A run of ones long enough to fill the whole shift word is taken as a preamble and puts the decoder back at bit zero, so software can always resynchronise.

Top module: `mdio_mgmt_responder`

## Requirements
- R1: The decoder counter and shift word change only on a system-clock cycle where the management-clock input is 1 and was 0 on the previous cycle. Holding that bit at either level, or changing the data or read-mode bits without a rising management clock, leaves the decoder state and the data-in output unchanged.
- R2: On each rising management-clock edge the counter value after the increment is n. The bit shifted into bit 0 of the word equals the data input when n < 16 or when read mode is 0. Otherwise a 0 is shifted in. With read mode held at 1 and the data input held at 1 through a read data phase, data-in therefore reads 0 on the 32nd edge.
- R3: An edge that leaves the shift word at all ones (0xFFFFFFFF) sets the counter to 0. This applies even when an earlier frame was cut off partway through.
- R4: When the counter reaches 16, word bits [15:12] hold the opcode, bits [11:7] hold the PHY address and bits [6:2] hold the register number. Opcode 6 replaces the whole shift word with the addressed register value, zero-extended.
- R5: Data-in is registered and resets to 0. On an edge with read mode at 1 and n >= 16, data-in takes bit 15 of the word after the shift. On all other edges data-in holds its value. For a read of value V, data-in shows 0 on edge 16, then V[31-n] on edges n = 17 to 31.
- R6: When the counter reaches 32, word bits [31:28] hold the opcode, bits [27:23] hold the PHY address, bits [22:18] hold the register number and bits [15:0] hold the data. Opcode 5 performs a register write.
- R7: Only PHY address 1 answers. A read at any other address returns 0. A write at any other address changes no register.
- R8: A write sets register bits only where that register's mask is 1. The masks are: 0xFFFF for registers 1, 2, 3, 5, 6 and 18 to 25; 0xC01F for register 4; 0x0FFF for register 16; 0x0000 for all others.
- R9: After reset the registers hold these values: register 0 = 0x3100, 1 = 0xF02C, 2 = 0x7810, 4 = 0x0501, 5 = 0x4181, 16 = 0x0003, 18 = 0x0001. Every other register holds 0.
- R10: A synchronous active-high reset clears the counter, the shift word and data-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_clk_bit | input | 1 | Management-clock bit as last written by software |
| mgmt_dout | input | 1 | Serial data bit sent by software |
| mgmt_rd_mode | input | 1 | Read-mode flag; 1 while software is collecting read data |
| mgmt_din | output | 1 | Registered serial data bit returned to software |

## Verification
The bench sends data-phase ones while read mode is set, so a design that shifted them in would show a 1 on the 32nd edge. Cut-off frames are followed by a preamble and a read. A counter that was not cleared would misalign the read header, and the wrong register would come back. Between serial bits the bench wiggles the data and read-mode inputs and holds the management clock high for several cycles; a level-triggered or double-counting decoder would shift extra bits and return garbage. Writes go to masked-off registers, to partly masked registers and to a foreign PHY address. Each is read back, so a write that ignored the mask or the address would show up as a wrong value.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;

  localparam int unsigned REG_COUNT = 32;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned FRAME_W   = 32;
  localparam int unsigned FIELD_W   = 5;
  localparam logic [3:0]  OPC_READ  = 4'd6;
  localparam logic [3:0]  OPC_WRITE = 4'd5;

  function automatic logic [DATA_W-1:0] reg_default(input int unsigned idx);
    case (idx)
      0:       return 16'h3100;
      1:       return 16'hF02C;
      2:       return 16'h7810;
      4:       return 16'h0501;
      5:       return 16'h4181;
      16:      return 16'h0003;
      18:      return 16'h0001;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_wmask(input int unsigned idx);
    if (idx == 4)                              return 16'hC01F;
    if (idx == 16)                             return 16'h0FFF;
    if ((idx >= 1 && idx <= 6) ||
        (idx >= 18 && idx <= 25))              return 16'hFFFF;
    return 16'h0000;
  endfunction

endpackage

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_resp_pkg::*;
#(
  parameter int unsigned FRAME_BITS = FRAME_W,
  parameter int unsigned DW         = DATA_W,
  parameter int unsigned AW         = FIELD_W,
  parameter int unsigned CNT_W      = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mdc,
  input  logic          dout,
  input  logic          rdmode,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_phy,
  output logic [AW-1:0] rd_reg,
  output logic          wr_en,
  output logic [AW-1:0] wr_phy,
  output logic [AW-1:0] wr_reg,
  output logic [DW-1:0] wr_data,
  output logic          din
);

  localparam int unsigned HDR_BITS = FRAME_BITS / 2;
  localparam logic [CNT_W-1:0] HDR_CNT  = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam int unsigned H_OPC = HDR_BITS - 1;
  localparam int unsigned H_PHY = HDR_BITS - 5;
  localparam int unsigned H_REG = H_PHY - AW;
  localparam int unsigned F_OPC = FRAME_BITS - 1;
  localparam int unsigned F_PHY = FRAME_BITS - 5;
  localparam int unsigned F_REG = F_PHY - AW;

  logic                  mdc_q;
  logic                  rise;
  logic [CNT_W-1:0]      cnt;
  logic [CNT_W-1:0]      cnt_inc;
  logic [FRAME_BITS-1:0] word;
  logic [FRAME_BITS-1:0] word_sh;
  logic                  shin;
  logic                  preamble;
  logic                  rd_hit;

  assign rise     = mdc & ~mdc_q;
  assign cnt_inc  = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  assign shin     = dout & ((cnt_inc < HDR_CNT) | ~rdmode);
  assign word_sh  = {word[FRAME_BITS-2:0], shin};
  assign preamble = &word_sh;

  assign rd_phy  = word_sh[H_PHY -: AW];
  assign rd_reg  = word_sh[H_REG -: AW];
  assign rd_hit  = rise & ~preamble & (cnt_inc == HDR_CNT) &
                   (word_sh[H_OPC -: 4] == OPC_READ);

  assign wr_phy  = word_sh[F_PHY -: AW];
  assign wr_reg  = word_sh[F_REG -: AW];
  assign wr_data = word_sh[DW-1:0];
  assign wr_en   = rise & ~preamble & (cnt_inc == FULL_CNT) &
                   (word_sh[F_OPC -: 4] == OPC_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_q <= 1'b0;
      cnt   <= '0;
      word  <= '0;
      din   <= 1'b0;
    end else begin
      mdc_q <= mdc;
      if (rise) begin
        cnt  <= preamble ? '0 : cnt_inc;
        word <= rd_hit ? {{(FRAME_BITS-DW){1'b0}}, rd_data} : word_sh;
        if (rdmode && cnt_inc >= HDR_CNT)
          din <= word_sh[HDR_BITS-1];
      end
    end
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rise |=> ($stable(cnt) && $stable(word)));

  // R3
  preamble_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && (&word_sh)) |=> (cnt == '0));

  // R5
  din_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rise && rdmode && cnt_inc >= HDR_CNT) |=> $stable(din));

  // R10
  reset_clr_chk: assert property (@(posedge clk)
    rst |=> (cnt == '0 && word == '0 && din == 1'b0));

endmodule

// File: rtl/mdio_phy_regfile.sv
module mdio_phy_regfile
  import mdio_resp_pkg::*;
#(
  parameter int unsigned REGS     = REG_COUNT,
  parameter int unsigned DW       = DATA_W,
  parameter int unsigned AW       = FIELD_W,
  parameter int unsigned PHY_ADDR = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_phy,
  input  logic [AW-1:0] rd_reg,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_phy,
  input  logic [AW-1:0] wr_reg,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  localparam logic [AW-1:0] MY_PHY = AW'(PHY_ADDR);

  logic [DW-1:0] mem [REGS];
  logic          wr_ok;

  assign wr_ok   = wr_en && (wr_phy == MY_PHY);
  assign rd_data = (rd_phy == MY_PHY) ? mem[rd_reg] : '0;

  for (genvar g = 0; g < REGS; g++) begin : g_reg
    localparam logic [DW-1:0] MASK_G = reg_wmask(g);
    localparam logic [DW-1:0] INIT_G = reg_default(g);

    always_ff @(posedge clk) begin
      if (rst)
        mem[g] <= INIT_G;
      else if (wr_ok && wr_reg == AW'(g))
        mem[g] <= (mem[g] & ~MASK_G) | (wr_data & MASK_G);
    end

    // R8
    wmask_hold_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (((mem[g] ^ $past(mem[g])) & ~MASK_G) == '0));

    // R7
    foreign_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_phy != MY_PHY) |=> $stable(mem[g]));
  end

endmodule

// File: rtl/mdio_mgmt_responder.sv
module mdio_mgmt_responder
  import mdio_resp_pkg::*;
#(
  parameter int unsigned PHY_ADDR = 1,
  parameter int unsigned CNT_W    = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic mgmt_clk_bit,
  input  logic mgmt_dout,
  input  logic mgmt_rd_mode,
  output logic mgmt_din
);

  logic [FIELD_W-1:0] rd_phy, rd_reg, wr_phy, wr_reg;
  logic [DATA_W-1:0]  rd_data, wr_data;
  logic               wr_en;

  mdio_frame_shifter #(
    .FRAME_BITS(FRAME_W), .DW(DATA_W), .AW(FIELD_W), .CNT_W(CNT_W)
  ) u_shift (
    .clk(clk), .rst(rst),
    .mdc(mgmt_clk_bit), .dout(mgmt_dout), .rdmode(mgmt_rd_mode),
    .rd_data(rd_data), .rd_phy(rd_phy), .rd_reg(rd_reg),
    .wr_en(wr_en), .wr_phy(wr_phy), .wr_reg(wr_reg), .wr_data(wr_data),
    .din(mgmt_din)
  );

  mdio_phy_regfile #(
    .REGS(REG_COUNT), .DW(DATA_W), .AW(FIELD_W), .PHY_ADDR(PHY_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst),
    .rd_phy(rd_phy), .rd_reg(rd_reg),
    .wr_en(wr_en), .wr_phy(wr_phy), .wr_reg(wr_reg), .wr_data(wr_data),
    .rd_data(rd_data)
  );

endmodule

// File: tb/mdio_mgmt_responder_test.sv
`timescale 1ns/1ps
module mdio_mgmt_responder_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mgmt_clk_bit = 1'b0;
  logic mgmt_dout = 1'b0;
  logic mgmt_rd_mode = 1'b0;
  logic mgmt_din;

  always #2 clk = ~clk;

  mdio_mgmt_responder uut (
    .clk(clk), .rst(rst), .mgmt_clk_bit(mgmt_clk_bit),
    .mgmt_dout(mgmt_dout), .mgmt_rd_mode(mgmt_rd_mode), .mgmt_din(mgmt_din)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic  exp;
    string req;
    int    edge_no;
  } sb_item_t;

  sb_item_t sbq[$];
  event sb_ev;
  logic [15:0] model [32];

  function automatic logic [15:0] exp_mask(input int r);
    if (r == 4)  return 16'hC01F;
    if (r == 16) return 16'h0FFF;
    if ((r >= 1 && r <= 6) || (r >= 18 && r <= 25)) return 16'hFFFF;
    return 16'h0000;
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: din actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(sb_ev);
      #1;
      while (sbq.size() > 0) begin
        sb_item_t it;
        it = sbq.pop_front();
        checks++;
        if (mgmt_din !== it.exp) begin
          failures++;
          $display("FAIL %s: edge %0d din actual=%0b expected=%0b",
                   it.req, it.edge_no, mgmt_din, it.exp);
        end
      end
    end
  end

  task automatic push_exp(input logic e, input string req, input int n);
    sb_item_t it;
    it.exp = e; it.req = req; it.edge_no = n;
    sbq.push_back(it);
    -> sb_ev;
  endtask

  task automatic clk_bit(input logic d);
    mgmt_dout = d;
    mgmt_clk_bit = 1'b0;
    repeat (2) @(negedge clk);
    mgmt_clk_bit = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic preamble();
    mgmt_rd_mode = 1'b0;
    for (int i = 0; i < 32; i++) clk_bit(1'b1);
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] ra,
                         input string tag, input bit glitch);
    logic [15:0] hdr;
    logic [15:0] val;
    hdr = {4'b0110, phy, ra, 2'b10};
    val = (phy == 5'd1) ? model[ra] : 16'h0000;
    preamble();
    mgmt_rd_mode = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      if (glitch && i == 7) begin
        // R1: wiggle data and read mode while the clock bit stays high
        for (int k = 0; k < 4; k++) begin
          mgmt_dout = ~mgmt_dout;
          mgmt_rd_mode = ~mgmt_rd_mode;
          @(negedge clk);
        end
        mgmt_rd_mode = 1'b1;
      end
      if (glitch && i == 6) begin
        // R1: clock held high for several cycles, data flips after the rise
        mgmt_dout = hdr[i];
        mgmt_clk_bit = 1'b0;
        repeat (2) @(negedge clk);
        mgmt_clk_bit = 1'b1;
        @(negedge clk);
        mgmt_dout = ~hdr[i];
        repeat (5) @(negedge clk);
      end else begin
        clk_bit(hdr[i]);
      end
    end
    push_exp(1'b0, "R4", 16);
    for (int n = 17; n <= 32; n++) begin
      clk_bit(1'b1);
      if (n <= 31) push_exp(val[31-n], tag, n);
      else         push_exp(1'b0, "R2", n);
    end
    mgmt_rd_mode = 1'b0;
  endtask

  task automatic do_write(input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] data);
    logic [31:0] frm;
    frm = {4'b0101, phy, ra, 2'b10, data};
    preamble();
    for (int i = 31; i >= 0; i--) clk_bit(frm[i]);
    if (phy == 5'd1)
      model[ra] = (model[ra] & ~exp_mask(ra)) | (data & exp_mask(ra));
  endtask

  initial begin
    for (int r = 0; r < 32; r++) model[r] = 16'h0000;
    model[0] = 16'h3100; model[1] = 16'hF02C; model[2] = 16'h7810;
    model[4] = 16'h0501; model[5] = 16'h4181; model[16] = 16'h0003;
    model[18] = 16'h0001;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(mgmt_din, 1'b0, "R10");

    // R9 reset values
    do_read(5'd1, 5'd0, "R9", 1'b0);
    do_read(5'd1, 5'd1, "R9", 1'b0);
    do_read(5'd1, 5'd2, "R9", 1'b0);
    do_read(5'd1, 5'd4, "R9", 1'b0);
    do_read(5'd1, 5'd16, "R9", 1'b0);
    do_read(5'd1, 5'd18, "R9", 1'b0);
    do_read(5'd1, 5'd7, "R9", 1'b0);

    // R7 foreign read returns zero
    do_read(5'd2, 5'd0, "R7", 1'b0);

    // R8 masked merges
    do_write(5'd1, 5'd4, 16'hFFFF);
    do_read(5'd1, 5'd4, "R8", 1'b0);
    do_write(5'd1, 5'd16, 16'h1234);
    do_read(5'd1, 5'd16, "R8", 1'b0);
    do_write(5'd1, 5'd0, 16'h0000);
    do_read(5'd1, 5'd0, "R8", 1'b0);

    // R7 foreign write ignored, R6 full write
    do_write(5'd3, 5'd1, 16'h0000);
    do_read(5'd1, 5'd1, "R7", 1'b0);
    do_write(5'd1, 5'd2, 16'h1111);
    do_read(5'd1, 5'd2, "R6", 1'b0);

    // R5 hold outside read mode: stop a read after edge 17 of register 1
    preamble();
    mgmt_rd_mode = 1'b1;
    begin
      logic [15:0] h;
      h = {4'b0110, 5'd1, 5'd1, 2'b10};
      for (int i = 15; i >= 0; i--) clk_bit(h[i]);
    end
    clk_bit(1'b1);
    check(mgmt_din, model[1][14], "R5");
    preamble();
    check(mgmt_din, model[1][14], "R5");

    // R1 glitches between serial bits
    do_read(5'd1, 5'd5, "R1", 1'b1);

    // R3 cut-off write header, then preamble and read
    for (int i = 0; i < 10; i++) clk_bit(i[0]);
    do_read(5'd1, 5'd18, "R3", 1'b0);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule